// File: doc/BRIEF.md
# Retriggerable One-Pulse Generator

This block drives a single output pulse from a trigger strobe. The trigger both clears and starts an internal counter, so the pulse has no programmable delay. It starts on the first clock edge that samples the trigger. Its length is set by an auto-reload value: the count runs from zero up to that value, or from that value down to zero. The pulse lasts auto-reload plus one cycles. A trigger that arrives while a pulse is running restarts the count, so a steady trigger stream holds the output active.

Two output modes give opposite output senses. A polarity input can invert the result again. The configuration is checked all the time. If the count alignment is anything other than edge-aligned, or if the compare value breaks the rule for the chosen direction, the block raises an error flag. While the flag is high it holds the output at its inactive level and ignores triggers.

Top module: `retrig_pulse_gen`

## Requirements
- R1: With no configuration error, a trigger high at a rising clock edge makes the output active from that edge onwards.
- R2: When counting up (`cfg_down_i`=0), an un-retriggered pulse lasts `cfg_arr_i`+1 clock cycles, then the output returns to inactive and stays there.
- R3: When counting down (`cfg_down_i`=1), an un-retriggered pulse also lasts `cfg_arr_i`+1 clock cycles, after which the output is inactive.
- R4: A trigger sampled while a pulse is active restarts the count, so the output stays active until `cfg_arr_i`+1 cycles after the last trigger.
- R5: A trigger sampled at the edge where the final count cycle would end restarts the count with no inactive cycle in between.
- R6: `cfg_mode_i`=0 selects mode 1, where the output is high when active and low when idle (with `cfg_pol_i`=0). `cfg_mode_i`=1 selects mode 2, which has the opposite levels.
- R7: `cfg_pol_i`=1 inverts the output level of both modes, in the active state and in the idle state.
- R8: `cfg_err_o` is high whenever `cfg_align_i` is not 2'b00 (edge-aligned). The values 2'b01, 2'b10 and 2'b11 are center-aligned settings.
- R9: `cfg_err_o` is high when counting up with `cfg_ccr_i` not equal to 0, or when counting down with `cfg_ccr_i` < `cfg_arr_i`. It is low for every valid setting.
- R10: While `cfg_err_o` is high, the output sits at its idle level and triggers are ignored. An error that appears during a pulse ends the pulse at once, and the pulse does not resume when the error clears.
- R11: During reset, and after reset until the first trigger, the output is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Trigger strobe; each cycle it is high counts as one trigger |
| cfg_down_i | input | 1 | Count direction: 0 up, 1 down |
| cfg_arr_i | input | CNT_W | Auto-reload value; the pulse lasts this value plus one cycles |
| cfg_ccr_i | input | CNT_W | Compare value; it must meet the rule for the chosen direction |
| cfg_mode_i | input | 1 | 0 selects mode 1, 1 selects mode 2 (opposite sense) |
| cfg_pol_i | input | 1 | Output polarity inversion |
| cfg_align_i | input | 2 | Alignment: 2'b00 edge-aligned, any other value center-aligned |
| pulse_o | output | 1 | Pulse output |
| cfg_err_o | output | 1 | Configuration error flag |

## Verification
The state that matters is the run flag and the count. A run flag stuck high, or one that was never set, shows at `pulse_o` on the first edge after the trigger. A count that starts at the wrong value or steps the wrong way makes the pulse too long or too short. That error appears on the edge where the pulse should end, so it is visible within `cfg_arr_i`+2 cycles. A restart that is missing or late leaves an inactive cycle in the middle of a retriggered pulse. A run flag that survives an error shows up as a pulse that resumes on the cycle after the error clears.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

  typedef enum logic [1:0] {
    RPG_ALIGN_EDGE = 2'b00,
    RPG_ALIGN_CTR1 = 2'b01,
    RPG_ALIGN_CTR2 = 2'b10,
    RPG_ALIGN_CTR3 = 2'b11
  } rpg_align_e;

  typedef enum logic {
    RPG_DIR_UP   = 1'b0,
    RPG_DIR_DOWN = 1'b1
  } rpg_dir_e;

  typedef enum logic {
    RPG_MODE_ONE = 1'b0,
    RPG_MODE_TWO = 1'b1
  } rpg_mode_e;

endpackage

// File: rtl/rpg_rst_sync.sv
module rpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/rpg_cfg_check.sv
module rpg_cfg_check
  import rpg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             down,
  input  logic [CNT_W-1:0] arr,
  input  logic [CNT_W-1:0] ccr,
  input  logic [1:0]       align,
  output logic             err
);

  logic align_bad;
  logic cmp_bad;

  always_comb begin
    align_bad = (rpg_align_e'(align) != RPG_ALIGN_EDGE);
    if (rpg_dir_e'(down) == RPG_DIR_DOWN) begin
      cmp_bad = (ccr < arr);
    end else begin
      cmp_bad = (ccr != '0);
    end
    err = align_bad | cmp_bad;
  end

endmodule

// File: rtl/rpg_counter.sv
module rpg_counter
  import rpg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             err,
  input  logic             down,
  input  logic [CNT_W-1:0] arr,
  output logic             run_q,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_end;
  logic             dir_dn;

  always_comb begin
    dir_dn = (rpg_dir_e'(down) == RPG_DIR_DOWN);
    at_end = dir_dn ? (cnt_q == '0) : (cnt_q >= arr);
    run_d  = run_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (err) begin
      run_d = 1'b0;
    end else if (trig) begin
      run_d  = 1'b1;
      cnt_en = 1'b1;
      cnt_d  = dir_dn ? arr : '0;
    end else if (run_q) begin
      if (at_end) begin
        run_d = 1'b0;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = dir_dn ? (cnt_q - ONE) : (cnt_q + ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/rpg_out_stage.sv
module rpg_out_stage
  import rpg_pkg::*;
(
  input  logic run,
  input  logic err,
  input  logic mode,
  input  logic pol,
  output logic pulse
);

  logic active;
  logic ref_lvl;

  always_comb begin
    active = run & ~err;
    if (rpg_mode_e'(mode) == RPG_MODE_TWO) begin
      ref_lvl = ~active;
    end else begin
      ref_lvl = active;
    end
    pulse = ref_lvl ^ pol;
  end

endmodule

// File: rtl/retrig_pulse_gen.sv
module retrig_pulse_gen #(
  parameter int CNT_W     = 8,
  parameter int RST_SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             cfg_down_i,
  input  logic [CNT_W-1:0] cfg_arr_i,
  input  logic [CNT_W-1:0] cfg_ccr_i,
  input  logic             cfg_mode_i,
  input  logic             cfg_pol_i,
  input  logic [1:0]       cfg_align_i,
  output logic             pulse_o,
  output logic             cfg_err_o
);

  logic             rst_sync_n;
  logic             err;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  rpg_rst_sync #(.STAGES(RST_SYNC)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rpg_cfg_check #(.CNT_W(CNT_W)) i_cfg_check (
    .down  (cfg_down_i),
    .arr   (cfg_arr_i),
    .ccr   (cfg_ccr_i),
    .align (cfg_align_i),
    .err   (err)
  );

  rpg_counter #(.CNT_W(CNT_W)) i_counter (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .trig  (trig_i),
    .err   (err),
    .down  (cfg_down_i),
    .arr   (cfg_arr_i),
    .run_q (run_q),
    .cnt_q (cnt_q)
  );

  rpg_out_stage i_out_stage (
    .run   (run_q),
    .err   (err),
    .mode  (cfg_mode_i),
    .pol   (cfg_pol_i),
    .pulse (pulse_o)
  );

  assign cfg_err_o = err;

endmodule

// File: rtl/rpg_checker.sv
module rpg_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             down,
  input logic [CNT_W-1:0] arr,
  input logic [CNT_W-1:0] ccr,
  input logic             mode,
  input logic             pol,
  input logic [1:0]       align,
  input logic             err,
  input logic             pulse,
  input logic             run,
  input logic [CNT_W-1:0] cnt
);

  // R1: an accepted trigger makes the output active on the next cycle
  a_r1_trig_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !err) |=> (err || (pulse == ~(mode ^ pol))));

  // R2: an up count never passes the auto-reload value
  a_r2_up_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !err && !down) |-> (cnt <= arr));

  // R3: a down count starts at the auto-reload value and stays at or below it
  a_r3_down_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !err && down) |-> (cnt <= arr));

  // R5: a retrigger in any running cycle keeps the pulse alive
  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && trig && !err) |=> run);

  // R8: a center-aligned setting is always flagged
  a_r8_center_err: assert property (@(posedge clk) disable iff (!rst_n)
    (align != 2'b00) |-> err);

  // R9: an up count with a nonzero compare value is flagged
  a_r9_up_cmp_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!down && (ccr != '0)) |-> err);

  // R10: an error forces the idle level and clears the run state
  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (pulse == (mode ^ pol)));

  a_r10_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !run);

  // R11: the run state is clear when the internal reset releases
  a_r11_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> !run);

endmodule

bind retrig_pulse_gen rpg_checker #(.CNT_W(CNT_W)) i_rpg_checker (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .trig  (trig_i),
  .down  (cfg_down_i),
  .arr   (cfg_arr_i),
  .ccr   (cfg_ccr_i),
  .mode  (cfg_mode_i),
  .pol   (cfg_pol_i),
  .align (cfg_align_i),
  .err   (cfg_err_o),
  .pulse (pulse_o),
  .run   (run_q),
  .cnt   (cnt_q)
);

// File: tb/test_retrig_pulse_gen.sv
module test_retrig_pulse_gen;

  localparam int CNT_W = 8;
  localparam int NVEC  = 8;

  logic             clk;
  logic             rst_n;
  logic             trig_i;
  logic             cfg_down_i;
  logic [CNT_W-1:0] cfg_arr_i;
  logic [CNT_W-1:0] cfg_ccr_i;
  logic             cfg_mode_i;
  logic             cfg_pol_i;
  logic [1:0]       cfg_align_i;
  logic             pulse_o;
  logic             cfg_err_o;

  int n_run;
  int n_fail;

  retrig_pulse_gen #(.CNT_W(CNT_W)) i_retrig_pulse_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .cfg_down_i  (cfg_down_i),
    .cfg_arr_i   (cfg_arr_i),
    .cfg_ccr_i   (cfg_ccr_i),
    .cfg_mode_i  (cfg_mode_i),
    .cfg_pol_i   (cfg_pol_i),
    .cfg_align_i (cfg_align_i),
    .pulse_o     (pulse_o),
    .cfg_err_o   (cfg_err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector fields: {down, mode, pol, arr[7:0], ccr[7:0], expected length[8:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 8'd5,   8'd0,   9'd6},
    {1'b0, 1'b1, 1'b0, 8'd0,   8'd0,   9'd1},
    {1'b1, 1'b0, 1'b0, 8'd7,   8'd7,   9'd8},
    {1'b1, 1'b0, 1'b1, 8'd3,   8'd200, 9'd4},
    {1'b0, 1'b1, 1'b1, 8'd12,  8'd0,   9'd13},
    {1'b1, 1'b1, 1'b0, 8'd0,   8'd0,   9'd1},
    {1'b0, 1'b0, 1'b1, 8'd255, 8'd0,   9'd256},
    {1'b1, 1'b0, 1'b0, 8'd20,  8'd21,  9'd21}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic dn, input logic [CNT_W-1:0] arr,
                         input logic [CNT_W-1:0] ccr, input logic md,
                         input logic pl, input logic [1:0] al);
    @(negedge clk);
    cfg_down_i  = dn;
    cfg_arr_i   = arr;
    cfg_ccr_i   = ccr;
    cfg_mode_i  = md;
    cfg_pol_i   = pl;
    cfg_align_i = al;
    @(posedge clk);
    #1;
  endtask

  // fires one trigger, counts consecutive active cycles
  task automatic fire_measure(input logic act_lvl, output int n);
    n = 0;
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    #1;
    while (pulse_o == act_lvl && n < 600) begin
      n++;
      @(negedge clk) trig_i = 1'b0;
      @(posedge clk);
      #1;
    end
    @(negedge clk) trig_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic idle;
    n_run  = 0;
    n_fail = 0;
    rst_n       = 1'b0;
    trig_i      = 1'b0;
    cfg_down_i  = 1'b0;
    cfg_arr_i   = 8'd5;
    cfg_ccr_i   = 8'd0;
    cfg_mode_i  = 1'b0;
    cfg_pol_i   = 1'b0;
    cfg_align_i = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check(pulse_o == 1'b0, "R11 idle during reset", pulse_o, 0);
    check(cfg_err_o == 1'b0, "R9 valid config no error", cfg_err_o, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(pulse_o == 1'b0, "R11 idle after reset", pulse_o, 0);

    // vector table: R2/R3 lengths, R6/R7 levels
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VEC[v][27], VEC[v][24:17], VEC[v][16:9], VEC[v][26], VEC[v][25], 2'b00);
      idle = VEC[v][26] ^ VEC[v][25];
      check(pulse_o == idle, "R6 R7 idle level", pulse_o, idle);
      check(cfg_err_o == 1'b0, "R9 valid config", cfg_err_o, 0);
      fire_measure(~idle, n);
      if (VEC[v][27]) check(n == int'(VEC[v][8:0]), "R3 down pulse length", n, VEC[v][8:0]);
      else            check(n == int'(VEC[v][8:0]), "R2 up pulse length", n, VEC[v][8:0]);
      check(pulse_o == idle, "R2 R3 returns idle", pulse_o, idle);
    end

    // R1: active right after the triggering edge
    set_cfg(1'b0, 8'd3, 8'd0, 1'b0, 1'b0, 2'b00);
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    #1;
    check(pulse_o == 1'b1, "R1 immediate start", pulse_o, 1);
    @(negedge clk) trig_i = 1'b0;
    repeat (6) @(posedge clk);
    #1;

    // R4: retrigger after 3 active cycles, arr=5 -> 3 + 6 = 9 cycles
    set_cfg(1'b0, 8'd5, 8'd0, 1'b0, 1'b0, 2'b00);
    n = 0;
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    #1;
    if (pulse_o) n++;
    @(negedge clk) trig_i = 1'b0;
    repeat (2) begin
      @(posedge clk);
      #1;
      if (pulse_o) n++;
    end
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    #1;
    if (pulse_o) n++;
    @(negedge clk) trig_i = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      #1;
      if (!pulse_o) break;
      n++;
    end
    check(n == 9, "R4 retrigger extends pulse", n, 9);

    // R5: trigger on the final-cycle edge, arr=4 -> 10 contiguous cycles
    set_cfg(1'b0, 8'd4, 8'd0, 1'b0, 1'b0, 2'b00);
    n = 0;
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    #1;
    if (pulse_o) n++;
    @(negedge clk) trig_i = 1'b0;
    repeat (4) begin
      @(posedge clk);
      #1;
      if (pulse_o) n++;
    end
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    #1;
    check(pulse_o == 1'b1, "R5 no gap at final cycle", pulse_o, 1);
    if (pulse_o) n++;
    @(negedge clk) trig_i = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      #1;
      if (!pulse_o) break;
      n++;
    end
    check(n == 10, "R5 total contiguous length", n, 10);

    // R5 counting down as well, arr=2 -> 3 + 3 = 6
    set_cfg(1'b1, 8'd2, 8'd2, 1'b0, 1'b0, 2'b00);
    n = 0;
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    #1;
    if (pulse_o) n++;
    @(negedge clk) trig_i = 1'b0;
    repeat (2) begin
      @(posedge clk);
      #1;
      if (pulse_o) n++;
    end
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    #1;
    if (pulse_o) n++;
    @(negedge clk) trig_i = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      #1;
      if (!pulse_o) break;
      n++;
    end
    check(n == 6, "R5 R3 down retrigger at end", n, 6);

    // R8: each center-aligned code raises the error
    for (int a = 1; a < 4; a++) begin
      set_cfg(1'b0, 8'd5, 8'd0, 1'b0, 1'b0, 2'(a));
      check(cfg_err_o == 1'b1, "R8 center alignment error", cfg_err_o, 1);
    end

    // R9: compare rule per direction
    set_cfg(1'b0, 8'd5, 8'd1, 1'b0, 1'b0, 2'b00);
    check(cfg_err_o == 1'b1, "R9 up with nonzero compare", cfg_err_o, 1);
    set_cfg(1'b1, 8'd10, 8'd9, 1'b0, 1'b0, 2'b00);
    check(cfg_err_o == 1'b1, "R9 down compare below reload", cfg_err_o, 1);
    set_cfg(1'b1, 8'd10, 8'd10, 1'b0, 1'b0, 2'b00);
    check(cfg_err_o == 1'b0, "R9 down compare equal reload", cfg_err_o, 0);

    // R10: trigger ignored under error, mode 2 idle level high
    set_cfg(1'b0, 8'd5, 8'd0, 1'b1, 1'b0, 2'b10);
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    #1;
    check(pulse_o == 1'b1, "R10 trigger ignored under error", pulse_o, 1);
    @(negedge clk) begin
      trig_i = 1'b0;
      cfg_align_i = 2'b00;
    end
    @(posedge clk);
    #1;
    check(pulse_o == 1'b1, "R10 no pulse after error clears", pulse_o, 1);

    // R10: error during a pulse ends it at once and it does not resume
    set_cfg(1'b0, 8'd20, 8'd0, 1'b0, 1'b0, 2'b00);
    @(negedge clk) trig_i = 1'b1;
    @(posedge clk);
    @(negedge clk) trig_i = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(pulse_o == 1'b1, "R10 pulse running before error", pulse_o, 1);
    @(negedge clk) cfg_align_i = 2'b01;
    #1;
    check(pulse_o == 1'b0, "R10 error ends pulse at once", pulse_o, 0);
    @(posedge clk);
    @(negedge clk) cfg_align_i = 2'b00;
    repeat (3) begin
      @(posedge clk);
      #1;
      check(pulse_o == 1'b0, "R10 pulse does not resume", pulse_o, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule